// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination MAC address. The address arrives from the receive path one byte per clock, first byte first. While the bytes stream in, a reflected CRC-32 is built up over them. Its lowest six bits, in reversed order, select one bit of a 64-bit hash table that software loads as two 32-bit halves. Multicast destinations pass when their table bit is set. Unicast destinations pass only on an exact match with the station address. Broadcast always passes, and a promiscuous control input makes every frame pass.

The verdict and the computed table index come out one cycle after the sixth address byte. A second, independent port lets the host give a whole address and read back its table index one cycle later. Software uses it to work out which table bits to set for a list of multicast groups.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset `decValid` and `hostIdxValid` are both low.
- R2: The table index is computed as follows. A CRC register starts at 0xFFFFFFFF. Address bytes are fed in arrival order, each one least significant bit first. Each bit step shifts the register right by one and XORs it with 0xEDB88320 when the old bit 0 differs from the input bit. The index is the low six bits of the final register in reversed order: index bit 5 is CRC bit 0 and index bit 0 is CRC bit 5. This index appears on `decHashIdx`.
- R3: A byte is taken on every cycle where `rxValid` is high. Cycles with `rxValid` low stall the address without losing any bytes. `decValid` is high for exactly one cycle, the cycle after the sixth byte is taken.
- R4: A multicast address is one whose first byte has bit 0 set and which is not all ones. It is accepted exactly when table bit `idx` is set. Indices 0 to 31 select bit `idx` of `tblLo`. Indices 32 to 63 select bit `idx-32` of `tblHi`.
- R5: The broadcast address (all 48 bits set) is accepted even when the table is all zeros.
- R6: A unicast address (first byte bit 0 clear) is accepted only when it equals the station address, whatever the table holds. `staLo[7:0]` holds byte 0, `staLo[15:8]` byte 1, `staLo[23:16]` byte 2 and `staLo[31:24]` byte 3. `staHi[7:0]` holds byte 4 and `staHi[15:8]` byte 5. Byte 0 is the first byte on the wire.
- R7: With `promiscEn` high, every address is accepted.
- R8: `rxValid` together with `rxStart` always begins a new address. Any partly received address is dropped.
- R9: While no address is in progress, bytes with `rxValid` high and `rxStart` low are ignored and produce no verdict.
- R10: A `hostReq` pulse raises `hostIdxValid` on the next cycle. At the same time `hostIdx` carries the R2 index of `hostAddr`, taken with byte 0 at bits 7:0, and `hostMcast` carries bit 0 of that byte.
- R11: With both table halves set to all ones, every multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Address byte present this cycle |
| rxStart | input | 1 | Marks the first byte of an address |
| rxByte | input | 8 | Address byte |
| promiscEn | input | 1 | Accept all frames |
| tblHi | input | 32 | Hash table bits 63..32 |
| tblLo | input | 32 | Hash table bits 31..0 |
| staHi | input | 16 | Station address bytes 5..4 |
| staLo | input | 32 | Station address bytes 3..0 |
| decValid | output | 1 | Verdict strobe |
| decAccept | output | 1 | Frame accepted |
| decHashIdx | output | 6 | Table index of the address |
| hostReq | input | 1 | Host index request |
| hostAddr | input | 48 | Address to hash, byte 0 in bits 7:0 |
| hostIdxValid | output | 1 | Host result strobe |
| hostIdx | output | 6 | Table index for the host address |
| hostMcast | output | 1 | Host address has the multicast bit |

## Verification
The hardest case to reach from the ports is a multicast address whose CRC-derived index lands in a chosen table bit. The index cannot be picked directly. The bench therefore generates pseudo-random multicast addresses and computes each index with its own arithmetic model. For every address it loads a table that is one-hot at the predicted index, and then its exact complement. This way every address is checked for both acceptance and rejection, and over the run the indices spread across both table halves. Restarts part way through an address and stall cycles between bytes are mixed into the same stream.

// File: rtl/mcast_filt_pkg.sv
package mcast_filt_pkg;
  localparam int MAC_BYTES = 6;
  localparam int ADDR_W    = MAC_BYTES * 8;
  localparam int HASH_W    = 6;
  localparam int TABLE_W   = 1 << HASH_W;
  localparam int HALF_W    = TABLE_W / 2;
  localparam int STA_HI_W  = ADDR_W - 32;
  localparam int CNT_W     = $clog2(MAC_BYTES + 1);
  localparam int CRC_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic             loadFirst;
    logic             stepByte;
    logic             finish;
    logic [CNT_W-1:0] byteIdx;
  } ctrl_strb_t;

  // one byte of a right-shifting CRC, least significant input bit first
  function automatic logic [CRC_W-1:0] crcStepByte(input logic [CRC_W-1:0] c,
                                                   input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // low hash bits taken in reversed order
  function automatic logic [HASH_W-1:0] foldIndex(input logic [CRC_W-1:0] c);
    logic [HASH_W-1:0] idx;
    for (int k = 0; k < HASH_W; k++) idx[k] = c[HASH_W-1-k];
    return idx;
  endfunction
endpackage

// File: rtl/mcast_filt_ctrl.sv
module mcast_filt_ctrl
  import mcast_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxStart,
  output ctrl_strb_t strb
);
  logic [CNT_W-1:0] byteCnt, byteCntNext;

  always_comb begin
    strb        = '0;
    byteCntNext = byteCnt;
    if (rxValid && rxStart) begin
      strb.loadFirst = 1'b1;
      strb.byteIdx   = '0;
      strb.finish    = (MAC_BYTES == 1);
      byteCntNext    = (MAC_BYTES == 1) ? '0 : CNT_W'(1);
    end else if (rxValid && byteCnt != '0) begin
      strb.stepByte = 1'b1;
      strb.byteIdx  = byteCnt;
      strb.finish   = (byteCnt == CNT_W'(MAC_BYTES - 1));
      byteCntNext   = strb.finish ? '0 : byteCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else       byteCnt <= byteCntNext;
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(MAC_BYTES - 1));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxStart) |=> (byteCnt == CNT_W'(1)));
  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt == '0 && rxValid && !rxStart) |=> (byteCnt == '0));
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadFirst, strb.stepByte}));
endmodule

// File: rtl/mcast_filt_datapath.sv
module mcast_filt_datapath
  import mcast_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strb_t          strb,
  input  logic [7:0]          rxByte,
  input  logic                promiscEn,
  input  logic [HALF_W-1:0]   tblHi,
  input  logic [HALF_W-1:0]   tblLo,
  input  logic [STA_HI_W-1:0] staHi,
  input  logic [31:0]         staLo,
  output logic                decValid,
  output logic                decAccept,
  output logic [HASH_W-1:0]   decHashIdx
);
  logic [CRC_W-1:0]           crcReg, crcSeed, crcNext;
  logic [MAC_BYTES-1:0][7:0]  addrBuf;
  logic [ADDR_W-1:0]          fullAddr, stationAddr;
  logic [TABLE_W-1:0]         hashTbl;
  logic [HASH_W-1:0]          idxNow;
  logic isMcast, isBcast, staMatch, tblHit, acceptNow;

  assign stationAddr = {staHi, staLo};
  assign hashTbl     = {tblHi, tblLo};

  always_comb begin
    crcSeed = strb.loadFirst ? '1 : crcReg;
    crcNext = crcStepByte(crcSeed, rxByte);
  end

  for (genvar gi = 0; gi < MAC_BYTES; gi++) begin : g_addr
    if (gi == MAC_BYTES - 1) begin : g_last
      assign fullAddr[8*gi +: 8] = rxByte;
    end else begin : g_held
      assign fullAddr[8*gi +: 8] = addrBuf[gi];
    end
  end

  always_comb begin
    idxNow    = foldIndex(crcNext);
    isMcast   = fullAddr[0];
    isBcast   = &fullAddr;
    staMatch  = (fullAddr == stationAddr);
    tblHit    = hashTbl[idxNow];
    acceptNow = promiscEn | isBcast | (isMcast ? tblHit : staMatch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg     <= '1;
      addrBuf    <= '0;
      decValid   <= 1'b0;
      decAccept  <= 1'b0;
      decHashIdx <= '0;
    end else begin
      if (strb.loadFirst || strb.stepByte) begin
        crcReg                <= crcNext;
        addrBuf[strb.byteIdx] <= rxByte;
      end
      decValid <= strb.finish;
      if (strb.finish) begin
        decAccept  <= acceptNow;
        decHashIdx <= idxNow;
      end
    end
  end

  a_r7_promisc_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && promiscEn) |=> (decValid && decAccept));
  a_r5_broadcast_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && (&fullAddr)) |=> decAccept);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);
endmodule

// File: rtl/mcast_filt_host_hash.sv
module mcast_filt_host_hash
  import mcast_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hostIdxValid,
  output logic [HASH_W-1:0] hostIdx,
  output logic              hostMcast
);
  logic [CRC_W-1:0] crcAll;

  always_comb begin
    crcAll = '1;
    for (int i = 0; i < MAC_BYTES; i++) crcAll = crcStepByte(crcAll, hostAddr[8*i +: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostIdxValid <= 1'b0;
      hostIdx      <= '0;
      hostMcast    <= 1'b0;
    end else begin
      hostIdxValid <= hostReq;
      if (hostReq) begin
        hostIdx   <= foldIndex(crcAll);
        hostMcast <= hostAddr[0];
      end
    end
  end

  a_r10_host_latency: assert property (@(posedge clk) disable iff (!rstN)
    hostReq |=> hostIdxValid);
  a_r10_host_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hostReq |=> !hostIdxValid);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mcast_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic                rxStart,
  input  logic [7:0]          rxByte,
  input  logic                promiscEn,
  input  logic [HALF_W-1:0]   tblHi,
  input  logic [HALF_W-1:0]   tblLo,
  input  logic [STA_HI_W-1:0] staHi,
  input  logic [31:0]         staLo,
  output logic                decValid,
  output logic                decAccept,
  output logic [HASH_W-1:0]   decHashIdx,
  input  logic                hostReq,
  input  logic [ADDR_W-1:0]   hostAddr,
  output logic                hostIdxValid,
  output logic [HASH_W-1:0]   hostIdx,
  output logic                hostMcast
);
  ctrl_strb_t strb;

  mcast_filt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxStart(rxStart), .strb(strb)
  );

  mcast_filt_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .promiscEn(promiscEn), .tblHi(tblHi), .tblLo(tblLo),
    .staHi(staHi), .staLo(staLo),
    .decValid(decValid), .decAccept(decAccept), .decHashIdx(decHashIdx)
  );

  mcast_filt_host_hash host_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostAddr(hostAddr),
    .hostIdxValid(hostIdxValid), .hostIdx(hostIdx), .hostMcast(hostMcast)
  );
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxStart = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        promiscEn = 1'b0;
  logic [31:0] tblHi = '0, tblLo = '0;
  logic [15:0] staHi = '0;
  logic [31:0] staLo = '0;
  logic        decValid, decAccept;
  logic [5:0]  decHashIdx;
  logic        hostReq = 1'b0;
  logic [47:0] hostAddr = '0;
  logic        hostIdxValid, hostMcast;
  logic [5:0]  hostIdx;

  int nChecks = 0, nFails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  mcast_hash_filter dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int modelIdx(input logic [47:0] a);
    longint crc = 64'hFFFF_FFFF;
    int idx = 0;
    for (int i = 0; i < 48; i++) begin
      if (((crc ^ longint'(a[i])) & 1) != 0) crc = (crc >> 1) ^ 64'hEDB8_8320;
      else crc = crc >> 1;
    end
    for (int b = 0; b < 6; b++) idx = idx * 2 + int'((crc >> b) & 1);
    return idx;
  endfunction

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // send six bytes, optional idle cycle after each non-final byte
  task automatic sendAddr(input logic [47:0] a, input bit gaps);
    for (int i = 0; i < 6; i++) begin
      rxValid = 1'b1; rxStart = (i == 0); rxByte = a[8*i +: 8];
      @(negedge clk);
      if (gaps && i < 5) begin
        rxValid = 1'b0; rxStart = 1'b0;
        @(negedge clk);
      end
    end
    rxValid = 1'b0; rxStart = 1'b0;
  endtask

  task automatic setTable(input logic [63:0] t);
    tblHi = t[63:32]; tblLo = t[31:0];
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [47:0] addr, sta;
    int idx;
    repeat (3) @(negedge clk);
    chk(decValid == 1'b0, "R1 decValid after reset", decValid, 0);
    chk(hostIdxValid == 1'b0, "R1 hostIdxValid after reset", hostIdxValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    sta = 48'h0A0B0C0D0E02;
    staHi = sta[47:32]; staLo = sta[31:0];

    // R2 R4 R10: multicast sweep, one-hot table then its complement
    for (int n = 0; n < 80; n++) begin
      addr = {nextRand()[15:0], nextRand()};
      addr[0] = 1'b1;
      if (&addr) addr[47] = 1'b0;
      idx = modelIdx(addr);
      setTable(64'd1 << idx);
      sendAddr(addr, n[2]);
      chk(decValid == 1'b1, "R3 verdict strobe", decValid, 1);
      chk(decHashIdx == 6'(idx), "R2 hash index", decHashIdx, idx);
      chk(decAccept == 1'b1, "R4 table bit set accepts", decAccept, 1);
      @(negedge clk);
      chk(decValid == 1'b0, "R3 strobe one cycle", decValid, 0);
      setTable(~(64'd1 << idx));
      sendAddr(addr, 1'b0);
      chk(decAccept == 1'b0, "R4 table bit clear rejects", decAccept, 0);
      hostReq = 1'b1; hostAddr = addr;
      @(negedge clk);
      hostReq = 1'b0;
      chk(hostIdxValid == 1'b1, "R10 host strobe", hostIdxValid, 1);
      chk(hostIdx == 6'(idx), "R10 host index", hostIdx, idx);
      chk(hostMcast == 1'b1, "R10 host mcast flag", hostMcast, 1);
      @(negedge clk);
    end

    // R10 on a unicast address
    hostReq = 1'b1; hostAddr = sta;
    @(negedge clk);
    hostReq = 1'b0;
    chk(hostIdx == 6'(modelIdx(sta)), "R10 host unicast index", hostIdx, modelIdx(sta));
    chk(hostMcast == 1'b0, "R10 host unicast flag", hostMcast, 0);

    // R11 all-ones table
    setTable('1);
    for (int n = 0; n < 8; n++) begin
      addr = {nextRand()[15:0], nextRand()}; addr[0] = 1'b1; addr[47] = 1'b0;
      sendAddr(addr, 1'b0);
      chk(decAccept == 1'b1, "R11 all-ones table", decAccept, 1);
    end

    // R6 unicast: table ignored, exact match only
    sendAddr(sta, 1'b1);
    chk(decAccept == 1'b1, "R6 station match", decAccept, 1);
    sendAddr(sta ^ 48'h8000_0000_0000, 1'b0);
    chk(decAccept == 1'b0, "R6 mismatch with full table", decAccept, 0);
    sendAddr(sta ^ 48'h0000_0000_0100, 1'b0);
    chk(decAccept == 1'b0, "R6 byte1 mismatch", decAccept, 0);
    setTable('0);
    sendAddr(sta, 1'b0);
    chk(decAccept == 1'b1, "R6 match with empty table", decAccept, 1);

    // R5 broadcast with empty table
    sendAddr('1, 1'b0);
    chk(decAccept == 1'b1, "R5 broadcast", decAccept, 1);
    chk(decHashIdx == 6'(modelIdx('1)), "R2 broadcast index", decHashIdx, modelIdx('1));

    // R7 promiscuous
    promiscEn = 1'b1;
    sendAddr(sta ^ 48'h0000_0000_0400, 1'b0);
    chk(decAccept == 1'b1, "R7 promisc unicast", decAccept, 1);
    sendAddr(48'h112233445501, 1'b0);
    chk(decAccept == 1'b1, "R7 promisc multicast", decAccept, 1);
    promiscEn = 1'b0;

    // R8 restart part way: three bytes of junk then the station address
    for (int i = 0; i < 3; i++) begin
      rxValid = 1'b1; rxStart = (i == 0); rxByte = 8'h55 + 8'(i);
      @(negedge clk);
    end
    sendAddr(sta, 1'b0);
    chk(decAccept == 1'b1, "R8 restart accepts new address", decAccept, 1);
    chk(decHashIdx == 6'(modelIdx(sta)), "R8 restart index", decHashIdx, modelIdx(sta));

    // R9 bytes without start while idle
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxValid = 1'b1; rxStart = 1'b0; rxByte = 8'hFF;
      @(negedge clk);
      chk(decValid == 1'b0, "R9 idle bytes ignored", decValid, 0);
    end
    rxValid = 1'b0;
    @(negedge clk);
    chk(decValid == 1'b0, "R9 no late verdict", decValid, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule